// File: doc/BRIEF.md
# Serial VFD Command Receiver

This block sits between a host's three-wire serial link (active-low select, shift clock, data) and the display memories of a dot-matrix fluorescent display controller. It gathers the incoming bits into bytes and decodes the first byte of each sequence as a command. The bytes that follow are steered into one of three memories: a 24-entry character-code RAM, a 16-entry 35-bit user-pattern RAM, or a 24-entry 4-bit symbol RAM. Each memory has its own address pointer that advances by itself. Single-byte commands load the general port, duty, digit-count and lamp-mode registers.

The memories themselves sit outside the block. It drives a write strobe, an address and data for each of them, and these are valid together for one system clock. All serial inputs are brought into the system clock domain before use.

Top module: `vfd_cmd_rx`

## Requirements
- R1: While `sel_ni` is low, a bit is taken from `sdat_i` on each rising edge of `sclk_i`. The first bit is byte bit 0. Bits are grouped in eights, and counting restarts whenever select goes high.
- R2: Bits 7:5 of a command byte choose the operation. 100 is a character-code write, 010 a pattern write, 110 a symbol write, 001 a port load, 101 a duty load, 011 a digit-count load, 111 a lamp-mode load and 000 a test command.
- R3: A character-code write takes its start address from bits 4:0 of the command byte. Each later byte is one code. It gives one `cc_we_o` pulse with `cc_addr_o` equal to the pointer and `cc_data_o` equal to the byte, and the pointer then advances by one.
- R4: Character-code bytes aimed at addresses 18h to 1Fh produce no strobe, but they still advance the 5-bit pointer, which wraps from 1Fh to 00h.
- R5: A symbol write follows the same addressing, drop and wrap rules as R3 and R4. It stores only bits 3:0 of each byte on `sym_data_o`.
- R6: A pattern write takes its address from bits 3:0 of the command byte, and each pattern needs five data bytes. Bit j (0..6) of data byte k (0..4) becomes pattern bit k+5j, and bit 7 is ignored. The fifth byte gives one `pat_we_o` pulse. The 4-bit pointer then advances, wrapping from 0Fh to 00h.
- R7: The port load copies bits 3:0 to `port_o`. The duty load copies bits 2:0 to `duty_o`. The digit-count load copies bits 3:0 to `digits_o`. The lamp-mode load copies bit 0 to `lamp_off_o` and bit 1 to `lamp_on_o`.
- R8: On reset, all pointers and strobes are 0, `port_o`, `duty_o` and `digits_o` are 0, `lamp_off_o` is 1 and `lamp_on_o` is 0.
- R9: When select rises, any partial byte and any partly received pattern are discarded. The next complete byte is decoded as a command.
- R10: The test command changes no output, and the byte after it is decoded as a command.
- R11: Every write strobe lasts one clock cycle, and at most one of the three strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_ni | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial shift clock |
| sdat_i | input | 1 | Serial data, LSB first |
| cc_we_o | output | 1 | Character-code RAM write strobe |
| cc_addr_o | output | 5 | Character-code RAM write address |
| cc_data_o | output | 8 | Character code to write |
| pat_we_o | output | 1 | Pattern RAM write strobe |
| pat_addr_o | output | 4 | Pattern RAM write address |
| pat_data_o | output | 35 | Assembled 35-bit pattern |
| sym_we_o | output | 1 | Symbol RAM write strobe |
| sym_addr_o | output | 5 | Symbol RAM write address |
| sym_data_o | output | 4 | Symbol bits to write |
| port_o | output | 4 | General output port bits |
| duty_o | output | 3 | Display duty setting |
| digits_o | output | 4 | Digit-count setting |
| lamp_off_o | output | 1 | Forced-off request |
| lamp_on_o | output | 1 | Forced-on request (has priority downstream) |

## Verification
The hardest states to reach from the ports are the pointer wrap states. The test must run the character-code or symbol pointer through all eight dead addresses without any strobe, and then see it land back on 00h. The pattern pointer must likewise roll from 0Fh to 00h after ten data bytes. The stimulus starts writes at addresses 16h, 17h and 0Fh and then keeps streaming data bytes within one select frame. Separate frames raise select in the middle of a byte and in the middle of a pattern, to show that the discarded bits leave no trace.

// File: rtl/vfd_rx_pkg.sv
package vfd_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int OP_LSB = 5;

  typedef enum logic [2:0] {
    OP_TEST   = 3'b000,
    OP_PORT   = 3'b001,
    OP_PAT    = 3'b010,
    OP_DIGITS = 3'b011,
    OP_CC     = 3'b100,
    OP_DUTY   = 3'b101,
    OP_SYM    = 3'b110,
    OP_LAMP   = 3'b111
  } op_e;

  typedef enum logic [1:0] {
    ST_CMD,
    ST_CC,
    ST_PAT,
    ST_SYM
  } seq_e;
endpackage

// File: rtl/vfd_rx_shift.sv
module vfd_rx_shift
  import vfd_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_ni,
  input  logic              sclk_i,
  input  logic              sdat_i,
  output logic              sel_hi_o,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [SYNC_STAGES-1:0] sel_sy, clk_sy, dat_sy;
  logic                   sclk_d;
  logic [BYTE_W-1:0]      sh_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   sel_s, sclk_s, dat_s, rise;
  logic [BYTE_W-1:0]      sh_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_sy <= '1;
      clk_sy <= '0;
      dat_sy <= '0;
      sclk_d <= 1'b0;
    end else begin
      sel_sy <= {sel_sy[SYNC_STAGES-2:0], sel_ni};
      clk_sy <= {clk_sy[SYNC_STAGES-2:0], sclk_i};
      dat_sy <= {dat_sy[SYNC_STAGES-2:0], sdat_i};
      sclk_d <= clk_sy[SYNC_STAGES-1];
    end
  end

  assign sel_s  = sel_sy[SYNC_STAGES-1];
  assign sclk_s = clk_sy[SYNC_STAGES-1];
  assign dat_s  = dat_sy[SYNC_STAGES-1];
  assign rise   = sclk_s & ~sclk_d;
  assign sh_nxt = {dat_s, sh_q[BYTE_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      cnt_q      <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
    end else begin
      byte_vld_o <= 1'b0;
      if (sel_s) begin
        cnt_q <= '0;
      end else if (rise) begin
        sh_q  <= sh_nxt;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(BYTE_W - 1)) begin
          byte_vld_o <= 1'b1;
          byte_o     <= sh_nxt;
        end
      end
    end
  end

  assign sel_hi_o = sel_s;
endmodule

// File: rtl/vfd_rx_pat.sv
module vfd_rx_pat #(
  parameter int COLS = 5,
  parameter int ROWS = 7,
  localparam int PAT_W = COLS * ROWS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             vld_i,
  input  logic [ROWS-1:0]  row_i,
  output logic             last_o,
  output logic [PAT_W-1:0] pat_o
);
  localparam int IDX_W = $clog2(COLS);

  logic [IDX_W-1:0] idx_q;
  logic [PAT_W-1:0] asm_w;

  assign last_o = (idx_q == IDX_W'(COLS - 1));

  // column k, row j -> pattern bit k + COLS*j
  for (genvar k = 0; k < COLS; k++) begin : g_col
    if (k < COLS - 1) begin : g_st
      logic [ROWS-1:0] c_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                  c_q <= '0;
        else if (vld_i && !clr_i && idx_q == IDX_W'(k)) c_q <= row_i;
      end
      for (genvar j = 0; j < ROWS; j++) begin : g_bit
        assign asm_w[k + COLS*j] = c_q[j];
      end
    end else begin : g_last
      for (genvar j = 0; j < ROWS; j++) begin : g_bit
        assign asm_w[k + COLS*j] = row_i[j];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      pat_o <= '0;
    end else if (clr_i) begin
      idx_q <= '0;
    end else if (vld_i) begin
      if (last_o) begin
        idx_q <= '0;
        pat_o <= asm_w;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vfd_rx_ctrl.sv
module vfd_rx_ctrl
  import vfd_rx_pkg::*;
#(
  parameter int CC_DEPTH = 24,
  parameter int CC_AW    = 5,
  parameter int CODE_W   = 8,
  parameter int PAT_AW   = 4,
  parameter int SYM_W    = 4,
  parameter int PORT_W   = 4,
  parameter int DUTY_W   = 3,
  parameter int DIG_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_hi_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              pat_last_i,
  output logic              pat_vld_o,
  output logic              pat_clr_o,
  output logic              cc_we_o,
  output logic [CC_AW-1:0]  cc_addr_o,
  output logic [CODE_W-1:0] cc_data_o,
  output logic              pat_we_o,
  output logic [PAT_AW-1:0] pat_addr_o,
  output logic              sym_we_o,
  output logic [CC_AW-1:0]  sym_addr_o,
  output logic [SYM_W-1:0]  sym_data_o,
  output logic [PORT_W-1:0] port_o,
  output logic [DUTY_W-1:0] duty_o,
  output logic [DIG_W-1:0]  digits_o,
  output logic              lamp_off_o,
  output logic              lamp_on_o
);
  localparam logic [CC_AW-1:0] CC_LAST = CC_AW'(CC_DEPTH - 1);

  seq_e              st_q;
  logic [CC_AW-1:0]  cc_ptr, sym_ptr;
  logic [PAT_AW-1:0] pat_ptr;
  op_e               op;

  assign op        = op_e'(byte_i[BYTE_W-1:OP_LSB]);
  assign pat_vld_o = byte_vld_i & ~sel_hi_i & (st_q == ST_PAT);
  assign pat_clr_o = sel_hi_i | (byte_vld_i & (st_q == ST_CMD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_CMD;
      cc_ptr     <= '0;
      sym_ptr    <= '0;
      pat_ptr    <= '0;
      cc_we_o    <= 1'b0;
      cc_addr_o  <= '0;
      cc_data_o  <= '0;
      pat_we_o   <= 1'b0;
      pat_addr_o <= '0;
      sym_we_o   <= 1'b0;
      sym_addr_o <= '0;
      sym_data_o <= '0;
      port_o     <= '0;
      duty_o     <= '0;
      digits_o   <= '0;
      lamp_off_o <= 1'b1;
      lamp_on_o  <= 1'b0;
    end else begin
      cc_we_o  <= 1'b0;
      pat_we_o <= 1'b0;
      sym_we_o <= 1'b0;
      if (sel_hi_i) begin
        st_q <= ST_CMD;
      end else if (byte_vld_i) begin
        case (st_q)
          ST_CMD: begin
            case (op)
              OP_CC: begin
                cc_ptr <= byte_i[CC_AW-1:0];
                st_q   <= ST_CC;
              end
              OP_PAT: begin
                pat_ptr <= byte_i[PAT_AW-1:0];
                st_q    <= ST_PAT;
              end
              OP_SYM: begin
                sym_ptr <= byte_i[CC_AW-1:0];
                st_q    <= ST_SYM;
              end
              OP_PORT:   port_o   <= byte_i[PORT_W-1:0];
              OP_DUTY:   duty_o   <= byte_i[DUTY_W-1:0];
              OP_DIGITS: digits_o <= byte_i[DIG_W-1:0];
              OP_LAMP: begin
                lamp_off_o <= byte_i[0];
                lamp_on_o  <= byte_i[1];
              end
              default: ; // test opcode: no effect
            endcase
          end
          ST_CC: begin
            if (cc_ptr <= CC_LAST) begin
              cc_we_o   <= 1'b1;
              cc_addr_o <= cc_ptr;
              cc_data_o <= byte_i[CODE_W-1:0];
            end
            cc_ptr <= cc_ptr + 1'b1;
          end
          ST_SYM: begin
            if (sym_ptr <= CC_LAST) begin
              sym_we_o   <= 1'b1;
              sym_addr_o <= sym_ptr;
              sym_data_o <= byte_i[SYM_W-1:0];
            end
            sym_ptr <= sym_ptr + 1'b1;
          end
          ST_PAT: begin
            if (pat_last_i) begin
              pat_we_o   <= 1'b1;
              pat_addr_o <= pat_ptr;
              pat_ptr    <= pat_ptr + 1'b1;
            end
          end
          default: st_q <= ST_CMD;
        endcase
      end
    end
  end
endmodule

// File: rtl/vfd_cmd_rx.sv
module vfd_cmd_rx
  import vfd_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CC_DEPTH    = 24,
  parameter int CC_AW       = 5,
  parameter int CODE_W      = 8,
  parameter int PAT_AW      = 4,
  parameter int PAT_COLS    = 5,
  parameter int PAT_ROWS    = 7,
  parameter int SYM_W       = 4,
  parameter int PORT_W      = 4,
  parameter int DUTY_W      = 3,
  parameter int DIG_W       = 4,
  localparam int PAT_W      = PAT_COLS * PAT_ROWS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_ni,
  input  logic              sclk_i,
  input  logic              sdat_i,
  output logic              cc_we_o,
  output logic [CC_AW-1:0]  cc_addr_o,
  output logic [CODE_W-1:0] cc_data_o,
  output logic              pat_we_o,
  output logic [PAT_AW-1:0] pat_addr_o,
  output logic [PAT_W-1:0]  pat_data_o,
  output logic              sym_we_o,
  output logic [CC_AW-1:0]  sym_addr_o,
  output logic [SYM_W-1:0]  sym_data_o,
  output logic [PORT_W-1:0] port_o,
  output logic [DUTY_W-1:0] duty_o,
  output logic [DIG_W-1:0]  digits_o,
  output logic              lamp_off_o,
  output logic              lamp_on_o
);
  logic              sel_hi, byte_vld;
  logic [BYTE_W-1:0] rx_byte;
  logic              pat_last, pat_vld, pat_clr;

  vfd_rx_shift #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_ni     (sel_ni),
    .sclk_i     (sclk_i),
    .sdat_i     (sdat_i),
    .sel_hi_o   (sel_hi),
    .byte_vld_o (byte_vld),
    .byte_o     (rx_byte)
  );

  vfd_rx_pat #(.COLS(PAT_COLS), .ROWS(PAT_ROWS)) u_pat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (pat_clr),
    .vld_i  (pat_vld),
    .row_i  (rx_byte[PAT_ROWS-1:0]),
    .last_o (pat_last),
    .pat_o  (pat_data_o)
  );

  vfd_rx_ctrl #(
    .CC_DEPTH (CC_DEPTH), .CC_AW (CC_AW), .CODE_W (CODE_W), .PAT_AW (PAT_AW),
    .SYM_W (SYM_W), .PORT_W (PORT_W), .DUTY_W (DUTY_W), .DIG_W (DIG_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_hi_i   (sel_hi),
    .byte_vld_i (byte_vld),
    .byte_i     (rx_byte),
    .pat_last_i (pat_last),
    .pat_vld_o  (pat_vld),
    .pat_clr_o  (pat_clr),
    .cc_we_o    (cc_we_o),
    .cc_addr_o  (cc_addr_o),
    .cc_data_o  (cc_data_o),
    .pat_we_o   (pat_we_o),
    .pat_addr_o (pat_addr_o),
    .sym_we_o   (sym_we_o),
    .sym_addr_o (sym_addr_o),
    .sym_data_o (sym_data_o),
    .port_o     (port_o),
    .duty_o     (duty_o),
    .digits_o   (digits_o),
    .lamp_off_o (lamp_off_o),
    .lamp_on_o  (lamp_on_o)
  );
endmodule

// File: rtl/vfd_cmd_rx_chk.sv
module vfd_cmd_rx_chk #(
  parameter int CC_DEPTH = 24,
  parameter int CC_AW    = 5,
  parameter int PORT_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_hi_i,
  input logic              byte_vld_i,
  input logic              cc_we_i,
  input logic [CC_AW-1:0]  cc_addr_i,
  input logic              pat_we_i,
  input logic              sym_we_i,
  input logic [CC_AW-1:0]  sym_addr_i,
  input logic [PORT_W-1:0] port_i
);
  localparam logic [CC_AW-1:0] CC_LAST = CC_AW'(CC_DEPTH - 1);

  assert_one_strobe_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cc_we_i, pat_we_i, sym_we_i}));

  assert_cc_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc_we_i |=> !cc_we_i);

  assert_pat_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pat_we_i |=> !pat_we_i);

  assert_cc_from_byte_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc_we_i |-> $past(byte_vld_i));

  assert_cc_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc_we_i |-> (cc_addr_i <= CC_LAST));

  assert_sym_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_we_i |-> (sym_addr_i <= CC_LAST));

  assert_port_update_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(port_i) |-> $past(byte_vld_i));

  assert_sel_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sel_hi_i) |-> !byte_vld_i);
endmodule

bind vfd_cmd_rx vfd_cmd_rx_chk #(.CC_DEPTH(CC_DEPTH), .CC_AW(CC_AW), .PORT_W(PORT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_hi_i   (sel_hi),
  .byte_vld_i (byte_vld),
  .cc_we_i    (cc_we_o),
  .cc_addr_i  (cc_addr_o),
  .pat_we_i   (pat_we_o),
  .sym_we_i   (sym_we_o),
  .sym_addr_i (sym_addr_o),
  .port_i     (port_o)
);

// File: tb/tb_vfd_cmd_rx.sv
module tb_vfd_cmd_rx;
  localparam int CLK_PERIOD = 10;
  localparam int PH = 4; // system clocks per shift-clock phase

  logic clk = 1'b0;
  logic rst_n, sel_n, sclk, sdat;
  logic cc_we, pat_we, sym_we;
  logic [4:0] cc_addr, sym_addr;
  logic [7:0] cc_data;
  logic [3:0] pat_addr, sym_data, port, digits;
  logic [34:0] pat_data;
  logic [2:0] duty;
  logic lamp_off, lamp_on;

  always #(CLK_PERIOD/2) clk = ~clk;

  vfd_cmd_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_ni(sel_n), .sclk_i(sclk), .sdat_i(sdat),
    .cc_we_o(cc_we), .cc_addr_o(cc_addr), .cc_data_o(cc_data),
    .pat_we_o(pat_we), .pat_addr_o(pat_addr), .pat_data_o(pat_data),
    .sym_we_o(sym_we), .sym_addr_o(sym_addr), .sym_data_o(sym_data),
    .port_o(port), .duty_o(duty), .digits_o(digits),
    .lamp_off_o(lamp_off), .lamp_on_o(lamp_on)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference model state
  int m_st = 0; // 0 command, 1 code, 2 pattern, 3 symbol
  int m_cc = 0, m_sym = 0, m_pat = 0, m_idx = 0;
  logic [34:0] m_acc = '0;
  logic [3:0] m_port = '0, m_digits = '0;
  logic [2:0] m_duty = '0;
  logic m_off = 1'b1, m_on = 1'b0;
  logic [12:0] cc_q[$];
  logic [38:0] pat_q[$];
  logic [8:0]  sym_q[$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_byte(input logic [7:0] b);
    case (m_st)
      0: case (b[7:5])
        3'b100: begin m_cc = int'(b[4:0]); m_st = 1; end
        3'b010: begin m_pat = int'(b[3:0]); m_idx = 0; m_st = 2; end
        3'b110: begin m_sym = int'(b[4:0]); m_st = 3; end
        3'b001: m_port = b[3:0];
        3'b101: m_duty = b[2:0];
        3'b011: m_digits = b[3:0];
        3'b111: begin m_off = b[0]; m_on = b[1]; end
        default: ;
      endcase
      1: begin
        if (m_cc < 24) cc_q.push_back({5'(m_cc), b});
        m_cc = (m_cc + 1) % 32;
      end
      3: begin
        if (m_sym < 24) sym_q.push_back({5'(m_sym), b[3:0]});
        m_sym = (m_sym + 1) % 32;
      end
      default: begin
        for (int j = 0; j < 7; j++) m_acc[m_idx + 5*j] = b[j];
        m_idx++;
        if (m_idx == 5) begin
          pat_q.push_back({4'(m_pat), m_acc});
          m_pat = (m_pat + 1) % 16;
          m_idx = 0;
        end
      end
    endcase
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sdat = b[i];
      idle(PH);
      sclk = 1'b1;
      idle(PH);
      sclk = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    model_byte(b);
    send_bits(b, 8);
  endtask

  task automatic frame_open();
    sel_n = 1'b0;
    idle(PH);
  endtask

  task automatic frame_close();
    idle(PH);
    sel_n = 1'b1;
    idle(8);
    m_st = 0;
    m_idx = 0;
  endtask

  task automatic check_regs(input string tag);
    idle(12);
    chk({tag, " port"}, 64'(port), 64'(m_port));
    chk({tag, " duty"}, 64'(duty), 64'(m_duty));
    chk({tag, " digits"}, 64'(digits), 64'(m_digits));
    chk({tag, " lamp_off"}, 64'(lamp_off), 64'(m_off));
    chk({tag, " lamp_on"}, 64'(lamp_on), 64'(m_on));
    chk({tag, " pending writes"}, 64'(cc_q.size() + pat_q.size() + sym_q.size()), 64'd0);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // strobe monitor, every clock (R3 R5 R6 R11)
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (cc_we) begin
        if (cc_q.size() == 0) chk("R4 unexpected code write", 64'({cc_addr, cc_data}), 64'h0);
        else chk("R3 code write", 64'({cc_addr, cc_data}), 64'(cc_q.pop_front()));
      end
      if (sym_we) begin
        if (sym_q.size() == 0) chk("R5 unexpected symbol write", 64'({sym_addr, sym_data}), 64'h0);
        else chk("R5 symbol write", 64'({sym_addr, sym_data}), 64'(sym_q.pop_front()));
      end
      if (pat_we) begin
        if (pat_q.size() == 0) chk("R6 unexpected pattern write", 64'({pat_addr, pat_data}), 64'h0);
        else chk("R6 pattern write", 64'({pat_addr, pat_data}), 64'(pat_q.pop_front()));
      end
      chk("R11 strobe overlap", 64'(32'(cc_we) + 32'(sym_we) + 32'(pat_we) > 1), 64'd0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rst_n = 1'b0; sel_n = 1'b1; sclk = 1'b0; sdat = 1'b0;
    idle(5);
    // R8 reset state
    chk("R8 cc_we", 64'(cc_we), 0);
    chk("R8 pat_we", 64'(pat_we), 0);
    chk("R8 sym_we", 64'(sym_we), 0);
    chk("R8 port", 64'(port), 0);
    chk("R8 duty", 64'(duty), 0);
    chk("R8 digits", 64'(digits), 0);
    chk("R8 lamp_off", 64'(lamp_off), 1);
    chk("R8 lamp_on", 64'(lamp_on), 0);
    rst_n = 1'b1;
    idle(5);

    // R1 R2 R7: several single-byte commands in one frame
    frame_open();
    send_byte(8'h2A); send_byte(8'hA5); send_byte(8'h6C); send_byte(8'hE2);
    frame_close();
    check_regs("R7 R1 loads");
    frame_open(); send_byte(8'hE3); frame_close(); check_regs("R7 lamp both");
    frame_open(); send_byte(8'hE1); send_byte(8'hA7); send_byte(8'h60); frame_close();
    check_regs("R7 lamp off");

    // R3 auto-increment
    frame_open();
    send_byte(8'h83); send_byte(8'h41); send_byte(8'h42); send_byte(8'hC3);
    frame_close();
    check_regs("R3 code run");

    // R4 drop 18h..1Fh and wrap to 00h
    frame_open();
    send_byte(8'h96);
    for (int i = 0; i < 11; i++) send_byte(8'(8'h50 + i));
    frame_close();
    check_regs("R4 code wrap");

    // R5 symbol: only low nibble, same wrap
    frame_open();
    send_byte(8'hD7); send_byte(8'hF9);
    for (int i = 0; i < 8; i++) send_byte(8'hEE);
    send_byte(8'h3C); send_byte(8'hA5);
    frame_close();
    check_regs("R5 symbol wrap");

    // R6 pattern interleave, bit 7 ignored, 0Fh -> 00h
    frame_open();
    send_byte(8'h4F);
    send_byte(8'h81); send_byte(8'h42); send_byte(8'hA4); send_byte(8'h18); send_byte(8'hFF);
    send_byte(8'h7F); send_byte(8'h00); send_byte(8'h55); send_byte(8'h2A); send_byte(8'h93);
    frame_close();
    check_regs("R6 pattern wrap");

    // R9 partial byte discarded
    frame_open(); send_bits(8'hFF, 3); frame_close();
    frame_open(); send_byte(8'h21); frame_close();
    check_regs("R9 partial byte");

    // R9 partial pattern discarded
    frame_open(); send_byte(8'h45); send_byte(8'h7E); send_byte(8'h11); frame_close();
    frame_open();
    send_byte(8'h47);
    send_byte(8'h01); send_byte(8'h02); send_byte(8'h04); send_byte(8'h08); send_byte(8'h10);
    frame_close();
    check_regs("R9 partial pattern");

    // R10 test opcode: no effect, next byte is a command
    frame_open(); send_byte(8'h81); frame_close();
    frame_open(); send_byte(8'h1F); frame_close();
    check_regs("R10 test ignored");
    frame_open(); send_byte(8'h00); send_byte(8'h2F); frame_close();
    check_regs("R10 command after test");

    // R2 R3 code write straight after single-byte commands in one frame
    frame_open();
    send_byte(8'hB3); send_byte(8'h80); send_byte(8'h99);
    frame_close();
    check_regs("R2 mixed frame");

    idle(20);
    report();
  end
endmodule